// File: doc/BRIEF.md
# Bitmap Multi-Block Allocation Unit

This unit hands out blocks of a shared memory pool. It is given an occupancy bitmap, with one bit per fixed-size block, and the number of blocks that a client wants. It returns a grant bitmap that marks the blocks to give to that client. The granted blocks do not have to be adjacent. The unit always takes the free blocks with the lowest indices first. If the pool has fewer free blocks than the request asks for, the unit reports a shortfall and grants nothing.

The request is sampled when a valid strobe is high. The unit returns its result one clock later with a matching valid flag. The result holds the grant bitmap, the failure flag and the occupancy bitmap as it stands after the allocation, which the surrounding control logic writes back to its table. The unit computes a parallel prefix count of free blocks and compares it with the request. It does not ripple serially across the bitmap.

Top module: `blkmap_alloc_unit`

## Requirements
- R1: In `occ_in`, a bit value of 0 means the block is free and 1 means it is in use. A `rsp_grant` bit is never set on a block that was in use.
- R2: On success, the granted blocks are exactly the `req_count` free blocks with the lowest indices. Bit i of `rsp_grant` corresponds to block i.
- R3: On success, the number of set bits in `rsp_grant` equals `req_count`. This includes a request for all N blocks when the whole pool is free.
- R4: When `req_count` is greater than the number of free blocks, `rsp_fail` is 1 and `rsp_grant` is all zeros.
- R5: On failure, `rsp_occ` equals the `occ_in` of that request.
- R6: On success, `rsp_occ` equals `occ_in` OR `rsp_grant`, and `rsp_fail` is 0.
- R7: A request with `req_count` = 0 succeeds with an all-zero grant, and `rsp_occ` equals `occ_in`.
- R8: `rsp_valid` is high in the cycle after `req_valid` is high and low otherwise. While no request is sampled, `rsp_grant`, `rsp_fail` and `rsp_occ` keep their last values.
- R9: After reset, `rsp_valid`, `rsp_fail`, `rsp_grant` and `rsp_occ` are all zero.
- R10: A `req_count` greater than N (possible because the count field is ceil(log2(N+1)) bits wide) always fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | The request on this cycle is sampled |
| req_count | input | CW (9) | Number of blocks wanted |
| occ_in | input | N (256) | Current occupancy, 1 = in use |
| rsp_valid | output | 1 | Result registers hold a new result |
| rsp_grant | output | N (256) | Blocks handed out by this request |
| rsp_fail | output | 1 | Not enough free blocks |
| rsp_occ | output | N (256) | Occupancy after the request |

## Verification
The bench targets three kinds of boundary case. The first is the exact-fit boundary, where the free count equals the request or falls short by one. The second is requests for zero blocks, for every block, and for more blocks than exist. The third is free blocks scattered at both ends of the bitmap.

Each error shows up in a specific way:
- An off-by-one in the prefix compare grants one block too many or one too few. It also moves the failure edge by one block.
- A scan that does not take the lowest free blocks first picks free blocks with higher indices.
- A failure path that does not clear the grant leaks a partial allocation into the written-back occupancy.
- A register that updates while idle changes the held outputs between requests.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

  // Width of a count that can represent 0..n inclusive.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

  // A block is taken when it is free and the number of free blocks
  // up to and including it (inclusive rank) does not exceed the request.
  function automatic logic slot_taken(input logic is_free,
                                      input int unsigned incl_rank,
                                      input int unsigned want);
    return is_free && (incl_rank <= want);
  endfunction

  // Shortfall: the whole pool offers fewer free blocks than requested.
  function automatic logic pool_short(input int unsigned total_free,
                                      input int unsigned want);
    return total_free < want;
  endfunction

endpackage

// File: rtl/blkmap_prefix_scan.sv
module blkmap_prefix_scan #(
  parameter int N  = 256,
  parameter int CW = 9
) (
  input  logic [N-1:0]         free_i,
  output logic [N-1:0][CW-1:0] incl_o
);
  localparam int LV = $clog2(N);

  // Log-depth inclusive prefix count of free bits (Kogge-Stone shape).
  for (genvar l = 0; l <= LV; l++) begin : g_lv
    logic [N-1:0][CW-1:0] s;
    if (l == 0) begin : g_seed
      always_comb begin
        for (int i = 0; i < N; i++) s[i] = CW'(free_i[i]);
      end
    end else begin : g_step
      localparam int STR = 1 << (l - 1);
      always_comb begin
        for (int i = 0; i < STR; i++) s[i] = g_lv[l-1].s[i];
        for (int i = STR; i < N; i++) s[i] = g_lv[l-1].s[i] + g_lv[l-1].s[i-STR];
      end
    end
  end

  assign incl_o = g_lv[LV].s;

endmodule

// File: rtl/blkmap_grant_pick.sv
module blkmap_grant_pick
  import blkmap_pkg::*;
#(
  parameter int N  = 256,
  parameter int CW = 9
) (
  input  logic [N-1:0]         free_i,
  input  logic [N-1:0][CW-1:0] incl_i,
  input  logic [CW-1:0]        want_i,
  output logic [N-1:0]         grant_o,
  output logic                 short_o
);
  always_comb begin
    for (int i = 0; i < N; i++)
      grant_o[i] = slot_taken(free_i[i], 32'(incl_i[i]), 32'(want_i));
  end

  assign short_o = pool_short(32'(incl_i[N-1]), 32'(want_i));

endmodule

// File: rtl/blkmap_alloc_unit.sv
module blkmap_alloc_unit
  import blkmap_pkg::*;
#(
  parameter int N  = 256,
  parameter int CW = cnt_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_count,
  input  logic [N-1:0]  occ_in,
  output logic          rsp_valid,
  output logic [N-1:0]  rsp_grant,
  output logic          rsp_fail,
  output logic [N-1:0]  rsp_occ
);
  // Named internal events
  logic [N-1:0]         scan_free;
  logic [N-1:0][CW-1:0] scan_rank;
  logic [N-1:0]         pick_grant;
  logic                 pick_short;
  logic [N-1:0]         next_grant;
  logic [N-1:0]         next_occ;

  assign scan_free = ~occ_in;

  blkmap_prefix_scan #(.N(N), .CW(CW)) scan_i (
    .free_i (scan_free),
    .incl_o (scan_rank)
  );

  blkmap_grant_pick #(.N(N), .CW(CW)) pick_i (
    .free_i  (scan_free),
    .incl_i  (scan_rank),
    .want_i  (req_count),
    .grant_o (pick_grant),
    .short_o (pick_short)
  );

  assign next_grant = pick_short ? '0 : pick_grant;
  assign next_occ   = occ_in | next_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= '0;
      rsp_fail  <= 1'b0;
      rsp_occ   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_grant <= next_grant;
        rsp_fail  <= pick_short;
        rsp_occ   <= next_occ;
      end
    end
  end

endmodule

// File: rtl/blkmap_alloc_chk.sv
module blkmap_alloc_chk #(
  parameter int N  = 256,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [CW-1:0] req_count,
  input logic [N-1:0]  occ_in,
  input logic          rsp_valid,
  input logic [N-1:0]  rsp_grant,
  input logic          rsp_fail,
  input logic [N-1:0]  rsp_occ
);
  // R1
  grant_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_grant & $past(occ_in)) == '0);
  // R3
  grant_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_fail || ($countones(rsp_grant) == int'($past(req_count))));
  // R4
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_fail == ($countones(~$past(occ_in)) < int'($past(req_count))));
  // R4
  fail_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fail) |-> rsp_grant == '0);
  // R6
  occ_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_occ == ($past(occ_in) | rsp_grant));
  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_grant) && $stable(rsp_occ) && $stable(rsp_fail));
endmodule

bind blkmap_alloc_unit blkmap_alloc_chk #(.N(N), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
  .occ_in(occ_in), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
  .rsp_fail(rsp_fail), .rsp_occ(rsp_occ)
);

// File: tb/blkmap_alloc_unit_tb.sv
module blkmap_alloc_unit_tb_top;
  localparam int N  = 256;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [CW-1:0] req_count = '0;
  logic [N-1:0]  occ_in = '0;
  logic          rsp_valid;
  logic [N-1:0]  rsp_grant;
  logic          rsp_fail;
  logic [N-1:0]  rsp_occ;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_tag = "R9";

  always #2.5 clk = ~clk;

  blkmap_alloc_unit #(.N(N), .CW(CW)) dut_i (
    .clk, .rst_n, .req_valid, .req_count, .occ_in,
    .rsp_valid, .rsp_grant, .rsp_fail, .rsp_occ
  );

  // Reference model state
  logic         m_valid = 0;
  logic [N-1:0] m_grant = '0;
  logic         m_fail = 0;
  logic [N-1:0] m_occ = '0;
  string        m_tag = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_grant = '0; m_fail = 0; m_occ = '0; m_tag = "R9";
    end else begin
      m_valid = req_valid;
      if (req_valid) begin
        int left;
        logic [N-1:0] g;
        left = int'(req_count);
        g = '0;
        for (int i = 0; i < N; i++)
          if (occ_in[i] == 1'b0 && left > 0) begin g[i] = 1'b1; left--; end
        m_fail  = (left > 0);
        m_grant = m_fail ? '0 : g;
        m_occ   = occ_in | m_grant;
        m_tag   = cur_tag;
      end else begin
        m_tag = "R8";
      end
    end
  end

  task automatic check_bit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_vec(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check_bit(m_tag, "rsp_valid", rsp_valid, m_valid);
      check_bit(m_tag, "rsp_fail", rsp_fail, m_fail);
      check_vec(m_tag, "rsp_grant", rsp_grant, m_grant);
      check_vec(m_tag, "rsp_occ", rsp_occ, m_occ);
    end
  end

  task automatic issue(logic [N-1:0] occ, int cnt, string tag);
    @(negedge clk);
    cur_tag   = tag;
    occ_in    = occ;
    req_count = CW'(cnt);
    req_valid = 1'b1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      occ_in    = ~occ_in;
      req_count = req_count + 1'b1;
    end
  endtask

  function automatic logic [N-1:0] rand_occ();
    logic [N-1:0] v;
    for (int w = 0; w < N / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [N-1:0] pat;
    repeat (3) @(negedge clk);  // R9 reset state compared each clock
    rst_n = 1'b1;
    issue('0, 5, "R2");                        // lowest five of an empty pool
    idle(2);                                   // R8 hold while idle
    issue('1, 1, "R4");                        // full pool: R4 and R5
    issue('0, 0, "R7");
    pat = '1; pat[3] = 0; pat[100] = 0; pat[255] = 0;
    issue(pat, 3, "R3");                       // exact fit, scattered
    issue(pat, 4, "R5");                       // one short
    issue(pat, 2, "R2");
    issue('0, N, "R3");                        // whole pool
    issue('0, 300, "R10");
    issue('0, N + 1, "R10");
    for (int i = 0; i < N; i++) pat[i] = i[0];
    issue(pat, 100, "R1");
    issue(pat, 128, "R6");
    issue(pat, 129, "R4");
    idle(1);
    for (int t = 0; t < 60; t++) begin
      logic [N-1:0] r;
      r = rand_occ();
      if (t % 3 == 0) r = r & rand_occ();
      issue(r, int'($urandom_range(0, 300)), "R6");
      if (t % 7 == 0) idle(1);
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule